// File: doc/BRIEF.md
# DMA Address Remapping Walker

This block sits between DMA-capable devices and host memory and turns every device-issued address into a host physical address. A request carries a 16-bit requester identity, made of an 8-bit bus number in the upper byte and an 8-bit device/function number in the lower byte, together with a 32-bit DMA virtual address. The block walks four 32-bit table entries in memory, one after another:

- a root table indexed by the bus number;
- a per-bus context table indexed by the device/function number;
- a page directory indexed by virtual address bits [31:22];
- a page table indexed by bits [21:12].

Bits [11:0] pass through unchanged as the page offset. In every table entry bit 0 is the present flag and bits [31:12] hold a 4 KB-aligned base address. Because each device reaches its own page structure through its context entry, it can only reach the pages that structure maps.

Completed translations are kept in a small fully associative cache. The cache tag is the requester identity together with the virtual page number. Software can clear the whole cache, or only the entries of one requester, by pulsing an invalidate command.

A failed walk returns an error response. It also pushes a record into a small fault FIFO. Each record holds the requester identity, the address and a 2-bit code naming the level whose entry was not present: 0 for the root, 1 for the context, 2 for the directory and 3 for the leaf.

The controller is one finite state machine with these states:

- IDLE: ready for a request; a valid request moves it to LOOKUP.
- LOOKUP: a cache hit goes to RESPOND; a miss goes to ROOT.
- ROOT, CTX, DIR, LEAF: each issues one memory read and waits for the data. A present entry advances ROOT to CTX, CTX to DIR, DIR to LEAF, and LEAF to RESPOND. A non-present entry goes straight to RESPOND with the matching fault code.
- RESPOND: drives the one-cycle response, pushes the fault record if the walk failed, and returns to IDLE.

Top module: `dma_remap_walker`

## Requirements
- R1: During and right after reset, req_ready is 1, and rsp_valid, mem_rd_req, flt_valid and flt_overflow are all 0.
- R2: On a cache miss the block reads, in this order: root_base + bus*4; then context base + devfn*4; then directory base + va[31:22]*4; then page-table base + va[21:12]*4. Each next base is bits [31:12] of the entry just read, with 12 zero bits appended.
- R3: When all four entries have bit 0 set, the response has rsp_ok=1 and rsp_hpa = {leaf[31:12], va[11:0]}.
- R4: The first entry with bit 0 clear ends the walk: no further reads, rsp_ok=0, rsp_hpa=0. The fault code is 0, 1, 2 or 3 for the root, context, directory or leaf level.
- R5: Each failed walk appends {requester, address, code} to the fault FIFO. Records appear at the flt_* head in arrival order, and flt_pop removes the head.
- R6: A fault arriving while the FIFO already holds FLT_DEPTH records is dropped and sets flt_overflow. The flag clears when a pop empties the FIFO.
- R7: A request whose requester and page are cached completes with no memory read and the cached result. The same page from another requester is not a hit.
- R8: Failed walks are not cached; repeating the request walks again.
- R9: A global invalidate removes every cached entry. A per-requester invalidate removes only the entries tagged with inv_rid.
- R10: An invalidate that covers the requester of a walk in progress stops that walk's result from being cached. The response itself is still delivered.
- R11: One request is handled at a time. req_ready is 1 only in IDLE, and every accepted request produces exactly one single-cycle rsp_valid pulse.
- R12: A new translation goes into the lowest free cache slot. When no slot is free, slots are replaced round-robin, starting from slot 0 after a global invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| root_base | input | 32 | Base address of the root table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_rid | input | 16 | Requester identity: bus in [15:8], device/function in [7:0] |
| req_dva | input | 32 | DMA virtual address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_hpa | output | 32 | Host physical address (0 on failure) |
| mem_rd_req | output | 1 | Table read request, held until data returns |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Table entry: bit 0 present, [31:12] base |
| inv_valid | input | 1 | Invalidate command strobe |
| inv_global | input | 1 | 1: clear all entries; 0: clear entries of inv_rid |
| inv_rid | input | 16 | Requester whose entries are cleared |
| flt_valid | output | 1 | Fault FIFO holds a record |
| flt_rid | output | 16 | Head record requester |
| flt_dva | output | 32 | Head record address |
| flt_code | output | 2 | Head record level code |
| flt_pop | input | 1 | Remove head record |
| flt_overflow | output | 1 | A fault record was dropped |

## Verification
The assertions assume a well-behaved memory port. mem_rd_valid rises only while mem_rd_req is high, and exactly once per read. The entry address and data do not change while a read is waiting. The bench's memory model answers one negative clock edge after it sees a request and then drops the strobe, so every read gets exactly one data beat. Requests are only offered while the block is idle, because the bench waits for each response before issuing the next. Invalidate pulses and pops last one cycle and are driven on falling edges.

// File: rtl/remap_pkg.sv
package remap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ROOT,
        ST_CTX,
        ST_DIR,
        ST_LEAF,
        ST_RESPOND
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_ROOT = 2'd0,
        FLT_CTX  = 2'd1,
        FLT_DIR  = 2'd2,
        FLT_LEAF = 2'd3
    } fault_code_e;

    localparam int ENT_SHIFT = 2;

endpackage

// File: rtl/remap_tlb.sv
module remap_tlb #(
    parameter int ENTRIES = 4,
    parameter int RID_W   = 16,
    parameter int VPN_W   = 20,
    parameter int DATA_W  = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [RID_W+VPN_W-1:0] lk_tag,
    output logic                   lk_hit,
    output logic [DATA_W-1:0]      lk_data,
    input  logic                   fill_en,
    input  logic [RID_W+VPN_W-1:0] fill_tag,
    input  logic [DATA_W-1:0]      fill_data,
    input  logic                   inv_en,
    input  logic                   inv_all,
    input  logic [RID_W-1:0]       inv_rid
);
    localparam int TAG_W = RID_W + VPN_W;
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DATA_W-1:0]  data_q [ENTRIES];
    logic [PTR_W-1:0]   rr_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] kill_vec;
    logic               has_free;
    logic [PTR_W-1:0]   free_idx;
    logic [PTR_W-1:0]   victim;
    logic               fill_ok;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign hit_vec[g]  = vld_q[g] && (tag_q[g] == lk_tag);
        assign kill_vec[g] = inv_en && (inv_all || (tag_q[g][TAG_W-1 -: RID_W] == inv_rid));
    end

    always_comb begin
        lk_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_data = lk_data | (data_q[i] & {DATA_W{hit_vec[i]}});
        end
    end
    assign lk_hit = |hit_vec;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                has_free = 1'b1;
                free_idx = PTR_W'(i);
            end
        end
    end

    assign victim  = has_free ? free_idx : rr_q;
    assign fill_ok = fill_en && !(inv_en && (inv_all || (fill_tag[TAG_W-1 -: RID_W] == inv_rid)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (kill_vec[i]) vld_q[i] <= 1'b0;
                if (fill_ok && (victim == PTR_W'(i))) begin
                    vld_q[i]  <= 1'b1;
                    tag_q[i]  <= fill_tag;
                    data_q[i] <= fill_data;
                end
            end
            if (inv_en && inv_all) begin
                rr_q <= '0;
            end else if (fill_ok && !has_free) begin
                rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    // R7: a tag lives in at most one slot
    p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9: a global invalidate leaves nothing valid
    p_global_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && inv_all) |=> (vld_q == '0));

endmodule

// File: rtl/remap_fault_fifo.sv
module remap_fault_fifo #(
    parameter int WIDTH = 50,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] count_q;
    logic             full, do_push, do_pop;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= '0;
            rd_q     <= '0;
            count_q  <= '0;
            overflow <= 1'b0;
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else begin
            if (do_push) begin
                store_q[wr_q] <= push_data;
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (do_pop) begin
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            count_q <= count_q + CNT_W'(do_push) - CNT_W'(do_pop);
            if (push && full) begin
                overflow <= 1'b1;
            end else if (do_pop && !do_push && (count_q == CNT_W'(1))) begin
                overflow <= 1'b0;
            end
        end
    end

    assign head_valid = (count_q != '0);
    assign head_data  = store_q[rd_q];

    // R6: a record arriving at a full FIFO raises the flag
    p_overflow_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> overflow);

    // R6: a dropped record leaves the stored count untouched
    p_drop_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count_q));

endmodule

// File: rtl/dma_remap_walker.sv
module dma_remap_walker
    import remap_pkg::*;
#(
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int RID_W       = 16,
    parameter int TLB_ENTRIES = 4,
    parameter int FLT_DEPTH   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [OFF_W+2*IDX_W-1:0]  root_base,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [RID_W-1:0]          req_rid,
    input  logic [OFF_W+2*IDX_W-1:0]  req_dva,
    output logic                      rsp_valid,
    output logic                      rsp_ok,
    output logic [OFF_W+2*IDX_W-1:0]  rsp_hpa,
    output logic                      mem_rd_req,
    output logic [OFF_W+2*IDX_W-1:0]  mem_rd_addr,
    input  logic                      mem_rd_valid,
    input  logic [OFF_W+2*IDX_W-1:0]  mem_rd_data,
    input  logic                      inv_valid,
    input  logic                      inv_global,
    input  logic [RID_W-1:0]          inv_rid,
    output logic                      flt_valid,
    output logic [RID_W-1:0]          flt_rid,
    output logic [OFF_W+2*IDX_W-1:0]  flt_dva,
    output logic [1:0]                flt_code,
    input  logic                      flt_pop,
    output logic                      flt_overflow
);
    localparam int ADDR_W = OFF_W + 2 * IDX_W;
    localparam int PG_W   = ADDR_W - OFF_W;
    localparam int HALF_W = RID_W / 2;
    localparam int REC_W  = RID_W + ADDR_W + 2;

    walk_state_e       state_q, state_d;
    logic [RID_W-1:0]  rid_q;
    logic [ADDR_W-1:0] dva_q, base_q, hpa_q;
    logic              ok_q, stale_q;
    fault_code_e       code_q, level_code;
    logic [IDX_W-1:0]  idx;
    logic              present, walking, tlb_hit, tlb_fill;
    logic [PG_W-1:0]   tlb_ppn;
    logic [ADDR_W-1:0] entry_base;
    logic [REC_W-1:0]  flt_rec;
    logic              unused_low;

    assign present    = mem_rd_data[0];
    assign entry_base = {mem_rd_data[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign unused_low = ^mem_rd_data[OFF_W-1:1];
    assign walking    = (state_q == ST_ROOT) || (state_q == ST_CTX) ||
                        (state_q == ST_DIR)  || (state_q == ST_LEAF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = tlb_hit ? ST_RESPOND : ST_ROOT;
            ST_ROOT:    if (mem_rd_valid) state_d = present ? ST_CTX  : ST_RESPOND;
            ST_CTX:     if (mem_rd_valid) state_d = present ? ST_DIR  : ST_RESPOND;
            ST_DIR:     if (mem_rd_valid) state_d = present ? ST_LEAF : ST_RESPOND;
            ST_LEAF:    if (mem_rd_valid) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // per-level index and fault code
    always_comb begin
        idx        = '0;
        level_code = FLT_ROOT;
        unique case (state_q)
            ST_ROOT: begin idx = IDX_W'(rid_q[RID_W-1 -: HALF_W]); level_code = FLT_ROOT; end
            ST_CTX:  begin idx = IDX_W'(rid_q[HALF_W-1:0]);        level_code = FLT_CTX;  end
            ST_DIR:  begin idx = dva_q[ADDR_W-1 -: IDX_W];         level_code = FLT_DIR;  end
            ST_LEAF: begin idx = dva_q[OFF_W +: IDX_W];            level_code = FLT_LEAF; end
            default: begin idx = '0;                               level_code = FLT_ROOT; end
        endcase
    end

    // walk context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rid_q   <= '0;
            dva_q   <= '0;
            base_q  <= '0;
            hpa_q   <= '0;
            ok_q    <= 1'b0;
            stale_q <= 1'b0;
            code_q  <= FLT_ROOT;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    rid_q   <= req_rid;
                    dva_q   <= req_dva;
                    stale_q <= 1'b0;
                end
                ST_LOOKUP: begin
                    base_q <= root_base;
                    if (tlb_hit) begin
                        ok_q  <= 1'b1;
                        hpa_q <= {tlb_ppn, dva_q[OFF_W-1:0]};
                    end
                end
                ST_ROOT, ST_CTX, ST_DIR, ST_LEAF: if (mem_rd_valid) begin
                    if (!present) begin
                        ok_q   <= 1'b0;
                        hpa_q  <= '0;
                        code_q <= level_code;
                    end else begin
                        base_q <= entry_base;
                        if (state_q == ST_LEAF) begin
                            ok_q  <= 1'b1;
                            hpa_q <= {mem_rd_data[ADDR_W-1:OFF_W], dva_q[OFF_W-1:0]};
                        end
                    end
                end
                ST_RESPOND: ;
                default: ;
            endcase
            if (walking && inv_valid && (inv_global || (inv_rid == rid_q))) stale_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_RESPOND);
        rsp_ok      = ok_q;
        rsp_hpa     = hpa_q;
        mem_rd_req  = walking;
        mem_rd_addr = base_q + ADDR_W'({idx, {ENT_SHIFT{1'b0}}});
        tlb_fill    = (state_q == ST_LEAF) && mem_rd_valid && present && !stale_q;
    end

    remap_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .RID_W   (RID_W),
        .VPN_W   (PG_W),
        .DATA_W  (PG_W)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    ({rid_q, dva_q[ADDR_W-1:OFF_W]}),
        .lk_hit    (tlb_hit),
        .lk_data   (tlb_ppn),
        .fill_en   (tlb_fill),
        .fill_tag  ({rid_q, dva_q[ADDR_W-1:OFF_W]}),
        .fill_data (mem_rd_data[ADDR_W-1:OFF_W]),
        .inv_en    (inv_valid),
        .inv_all   (inv_global),
        .inv_rid   (inv_rid)
    );

    remap_fault_fifo #(
        .WIDTH (REC_W),
        .DEPTH (FLT_DEPTH)
    ) u_flog (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       ((state_q == ST_RESPOND) && !ok_q),
        .push_data  ({rid_q, dva_q, code_q}),
        .pop        (flt_pop),
        .head_valid (flt_valid),
        .head_data  (flt_rec),
        .overflow   (flt_overflow)
    );

    assign flt_rid  = flt_rec[REC_W-1 -: RID_W];
    assign flt_dva  = flt_rec[2 +: ADDR_W];
    assign flt_code = flt_rec[1:0];

    // R11: the response strobe lasts one cycle
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: once a request is taken the block stops accepting
    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: a failed response always leaves a record in the log
    p_fault_logged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |=> flt_valid);

    // R7: a cache hit issues no table read
    p_hit_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && tlb_hit) |=> !mem_rd_req);

endmodule

// File: tb/dma_remap_walker_tb.sv
`timescale 1ns/1ps
module dma_remap_walker_tb;

    localparam logic [31:0] ROOT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = ROOT;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_rid = '0;
    logic [31:0] req_dva = '0;
    logic        rsp_valid, rsp_ok;
    logic [31:0] rsp_hpa;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        inv_valid = 1'b0, inv_global = 1'b0;
    logic [15:0] inv_rid = '0;
    logic        flt_valid;
    logic [15:0] flt_rid;
    logic [31:0] flt_dva;
    logic [1:0]  flt_code;
    logic        flt_pop = 1'b0;
    logic        flt_overflow;

    always #10 clk = ~clk;

    dma_remap_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_rid(req_rid), .req_dva(req_dva),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_hpa(rsp_hpa),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .inv_valid(inv_valid), .inv_global(inv_global), .inv_rid(inv_rid),
        .flt_valid(flt_valid), .flt_rid(flt_rid), .flt_dva(flt_dva), .flt_code(flt_code),
        .flt_pop(flt_pop), .flt_overflow(flt_overflow)
    );

    int checks = 0;
    int fails  = 0;
    int mem_reads = 0;
    logic [31:0] alog [0:1023];
    logic [31:0] mem [logic [31:0]];
    logic        ok_r;
    logic [31:0] hpa_r;
    int          reads_r;
    int          start_r;

    // memory model: one data beat per read, on the falling edge after the request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req && !mem_rd_valid) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
                alog[mem_reads[9:0]] = mem_rd_addr;
                mem_reads++;
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ctx_base(input logic [15:0] rid);
        return 32'h0100_0000 + ({24'h0, rid[15:8]} << 12);
    endfunction
    function automatic logic [31:0] pd_base(input logic [15:0] rid);
        return 32'h0200_0000 + ({16'h0, rid} << 12);
    endfunction
    function automatic logic [31:0] pt_base(input logic [15:0] rid, input logic [31:0] dva);
        return 32'h1000_0000 + ({28'h0, rid[3:0]} << 24) + ({22'h0, dva[31:22]} << 12);
    endfunction
    function automatic logic [31:0] a_root(input logic [15:0] rid);
        return ROOT + {22'h0, rid[15:8], 2'b00};
    endfunction
    function automatic logic [31:0] a_ctx(input logic [15:0] rid);
        return ctx_base(rid) + {22'h0, rid[7:0], 2'b00};
    endfunction
    function automatic logic [31:0] a_dir(input logic [15:0] rid, input logic [31:0] dva);
        return pd_base(rid) + {20'h0, dva[31:22], 2'b00};
    endfunction
    function automatic logic [31:0] a_leaf(input logic [15:0] rid, input logic [31:0] dva);
        return pt_base(rid, dva) + {20'h0, dva[21:12], 2'b00};
    endfunction

    task automatic map_page(input logic [15:0] rid, input logic [31:0] dva, input logic [19:0] ppn);
        mem[a_root(rid)]     = ctx_base(rid) | 32'h1;
        mem[a_ctx(rid)]      = pd_base(rid) | 32'h1;
        mem[a_dir(rid, dva)] = pt_base(rid, dva) | 32'h1;
        mem[a_leaf(rid, dva)] = {ppn, 12'h001};
    endtask

    task automatic do_req(input logic [15:0] rid, input logic [31:0] dva,
                          input bit inv_mid, input bit inv_g);
        int w;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready before request", {63'h0, req_ready}, 64'h1);
        req_valid = 1'b1; req_rid = rid; req_dva = dva; start_r = mem_reads;
        @(negedge clk);
        req_valid = 1'b0;
        if (inv_mid) begin
            @(negedge clk);
            inv_valid = 1'b1; inv_global = inv_g; inv_rid = rid;
            @(negedge clk);
            inv_valid = 1'b0;
        end
        w = 0;
        while (!rsp_valid && w < 300) begin
            @(negedge clk);
            w++;
        end
        chk(w < 300, "R11", "response arrives", 64'(w), 64'h0);
        ok_r = rsp_ok; hpa_r = rsp_hpa; reads_r = mem_reads - start_r;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R11", "single-cycle response, back to idle",
            {62'h0, rsp_valid, req_ready}, 64'h1);
    endtask

    task automatic do_inv(input bit g, input logic [15:0] rid);
        @(negedge clk);
        inv_valid = 1'b1; inv_global = g; inv_rid = rid;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic do_pop();
        @(negedge clk);
        flt_pop = 1'b1;
        @(negedge clk);
        flt_pop = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [31:0] hpa, input int reads);
        chk(ok_r == 1'b1, req, "rsp_ok", {63'h0, ok_r}, 64'h1);
        chk(hpa_r == hpa, req, "rsp_hpa", {32'h0, hpa_r}, {32'h0, hpa});
        chk(reads_r == reads, req, "table reads", 64'(reads_r), 64'(reads));
    endtask

    task automatic expect_fault(input string req, input int reads);
        chk(ok_r == 1'b0 && hpa_r == 32'h0, req, "error response",
            {31'h0, ok_r, hpa_r}, 64'h0);
        chk(reads_r == reads, req, "reads before stop", 64'(reads_r), 64'(reads));
    endtask

    task automatic expect_rec(input string req, input logic [15:0] rid,
                              input logic [31:0] dva, input logic [1:0] code);
        chk(flt_valid && flt_rid == rid && flt_dva == dva && flt_code == code, req,
            "fault record {valid,rid,dva,code}",
            {13'h0, flt_valid, flt_rid, flt_dva, flt_code},
            {13'h0, 1'b1, rid, dva, code});
        do_pop();
    endtask

    task automatic t_reset();
        // R1
        chk(req_ready && !rsp_valid && !mem_rd_req && !flt_valid && !flt_overflow, "R1",
            "reset outputs", {59'h0, req_ready, rsp_valid, mem_rd_req, flt_valid, flt_overflow},
            64'h10);
    endtask

    task automatic t_walk();
        map_page(16'h0312, 32'h0040_5123, 20'hABCDE);
        do_req(16'h0312, 32'h0040_5123, 1'b0, 1'b0);
        expect_ok("R3", 32'hABCD_E123, 4);
        chk(alog[start_r[9:0]] == 32'h0001_000C, "R2", "root entry address",
            {32'h0, alog[start_r[9:0]]}, 64'h0001_000C);
        chk(alog[10'(start_r + 1)] == 32'h0100_3048, "R2", "context entry address",
            {32'h0, alog[10'(start_r + 1)]}, 64'h0100_3048);
        chk(alog[10'(start_r + 2)] == 32'h0231_2004, "R2", "directory entry address",
            {32'h0, alog[10'(start_r + 2)]}, 64'h0231_2004);
        chk(alog[10'(start_r + 3)] == 32'h1200_1014, "R2", "leaf entry address",
            {32'h0, alog[10'(start_r + 3)]}, 64'h1200_1014);
    endtask

    task automatic t_hit();
        do_req(16'h0312, 32'h0040_5FF0, 1'b0, 1'b0);
        expect_ok("R7", 32'hABCD_EFF0, 0);
        map_page(16'h0423, 32'h0040_5000, 20'h12345);
        do_req(16'h0423, 32'h0040_5008, 1'b0, 1'b0);
        expect_ok("R7", 32'h1234_5008, 4);
    endtask

    task automatic t_faults();
        do_req(16'h0501, 32'h0000_0100, 1'b0, 1'b0);
        expect_fault("R4", 1);
        map_page(16'h0602, 32'h0000_1000, 20'h00001);
        mem[a_ctx(16'h0602)] = 32'h0;
        do_req(16'h0602, 32'h0000_1000, 1'b0, 1'b0);
        expect_fault("R4", 2);
        map_page(16'h0703, 32'h0080_2000, 20'h00002);
        mem[a_dir(16'h0703, 32'h0080_2000)] = 32'h0;
        do_req(16'h0703, 32'h0080_2000, 1'b0, 1'b0);
        expect_fault("R4", 3);
        map_page(16'h0804, 32'h00C0_3000, 20'h00003);
        mem[a_leaf(16'h0804, 32'h00C0_3000)] = 32'h0;
        do_req(16'h0804, 32'h00C0_3000, 1'b0, 1'b0);
        expect_fault("R4", 4);
        expect_rec("R5", 16'h0501, 32'h0000_0100, 2'd0);
        expect_rec("R5", 16'h0602, 32'h0000_1000, 2'd1);
        expect_rec("R5", 16'h0703, 32'h0080_2000, 2'd2);
        expect_rec("R5", 16'h0804, 32'h00C0_3000, 2'd3);
        // R8: a repeated failing request walks again
        do_req(16'h0501, 32'h0000_0100, 1'b0, 1'b0);
        expect_fault("R8", 1);
        expect_rec("R8", 16'h0501, 32'h0000_0100, 2'd0);
        chk(!flt_valid, "R5", "log empty after pops", {63'h0, flt_valid}, 64'h0);
    endtask

    task automatic t_inval();
        do_inv(1'b0, 16'h0312);
        do_req(16'h0423, 32'h0040_5010, 1'b0, 1'b0);
        expect_ok("R9", 32'h1234_5010, 0);
        do_req(16'h0312, 32'h0040_5010, 1'b0, 1'b0);
        expect_ok("R9", 32'hABCD_E010, 4);
        do_inv(1'b1, 16'h0000);
        do_req(16'h0312, 32'h0040_5020, 1'b0, 1'b0);
        expect_ok("R9", 32'hABCD_E020, 4);
        do_req(16'h0423, 32'h0040_5020, 1'b0, 1'b0);
        expect_ok("R9", 32'h1234_5020, 4);
    endtask

    task automatic t_stale();
        map_page(16'h0905, 32'h0100_0000, 20'h55555);
        do_req(16'h0905, 32'h0100_0004, 1'b1, 1'b0);
        expect_ok("R10", 32'h5555_5004, 4);
        do_req(16'h0905, 32'h0100_0004, 1'b0, 1'b0);
        expect_ok("R10", 32'h5555_5004, 4);
        do_req(16'h0905, 32'h0100_0008, 1'b0, 1'b0);
        expect_ok("R10", 32'h5555_5008, 0);
    endtask

    task automatic t_replace();
        do_inv(1'b1, 16'h0000);
        for (int n = 0; n < 5; n++) begin
            map_page(16'h0A06, 32'(n) << 12, 20'(32'h70 + n));
            do_req(16'h0A06, 32'(n) << 12, 1'b0, 1'b0);
            expect_ok("R12", {20'(32'h70 + n), 12'h000}, 4);
        end
        do_req(16'h0A06, 32'h0000_1000, 1'b0, 1'b0);
        expect_ok("R12", 32'h0007_1000, 0);
        do_req(16'h0A06, 32'h0000_0000, 1'b0, 1'b0);
        expect_ok("R12", 32'h0007_0000, 4);
    endtask

    task automatic t_overflow();
        for (int n = 0; n < 5; n++) begin
            do_req(16'h0501, 32'h0000_0010 + 32'(n), 1'b0, 1'b0);
        end
        chk(flt_overflow == 1'b1, "R6", "overflow flag set", {63'h0, flt_overflow}, 64'h1);
        expect_rec("R6", 16'h0501, 32'h0000_0010, 2'd0);
        do_pop();
        do_pop();
        chk(flt_overflow == 1'b1, "R6", "flag held while records remain",
            {63'h0, flt_overflow}, 64'h1);
        expect_rec("R6", 16'h0501, 32'h0000_0013, 2'd0);
        chk(!flt_overflow && !flt_valid, "R6", "flag cleared on drain",
            {62'h0, flt_overflow, flt_valid}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk();
        t_hit();
        t_faults();
        t_inval();
        t_stale();
        t_replace();
        t_overflow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule